// File: doc/BRIEF.md
# ADC conversion and readout controller

This block runs a 16-bit successive-approximation converter from the host side of a three-wire serial link in which the converter's data line also serves as its busy flag. A start request raises the convert output. The output drops again after a short programmed pulse, well before the shortest conversion can end, and stays low. While the converter works, its data line is released and a pull-up holds it high. The controller waits for that line to be driven low, which marks the end of the conversion.

Once the end of conversion is seen, the controller produces a serial clock that idles low and issues seventeen falling edges. The converter launches one bit on each falling edge, most significant bit first. The controller takes each bit on the following falling edge. The seventeenth edge captures the last bit and makes the converter release the line. The finished word is then presented together with a one-cycle valid strobe. If the line never goes low, a timeout counted from the convert rise raises a one-cycle error flag, and the controller returns to idle without a valid strobe.

The data line passes through a two-flop synchronizer before it reaches busy detection and bit capture. All timing values are parameters counted in system clock cycles.

Top module: `adc_rdout_ctrl`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, convert and serial clock are low, valid and error are low, and the sample output is zero.
- R2: A start request accepted in idle drives the convert output high in the next cycle. It then stays high for exactly CNV_HI cycles, where CNV_HI is required to be below the minimum conversion time T_MIN.
- R3: A start request made while a conversion or readout is in progress is ignored, so exactly one convert rise occurs per transaction.
- R4: While the synchronized data line reads high (released), no serial clock edge is produced. Readout begins only after the line has been seen low.
- R5: Each readout produces exactly 17 falling serial clock edges. Each high and each low phase between edges lasts HALF system cycles, and the serial clock is low whenever the controller is idle.
- R6: The sample is assembled MSB first. The bit captured at falling edge k (k = 2..17) lands in bit 17-k of the 16-bit result, so edge 2 gives bit 15 and edge 17 gives bit 0.
- R7: The valid strobe lasts exactly one cycle. It is high in the same cycle in which the serial clock first reads low after its 17th falling edge.
- R8: If the data line is not seen low, the error flag pulses for one cycle exactly T_MAX+TMO cycles after the convert output rose. No serial clock edge and no valid strobe occur, and the controller returns to idle and accepts the next start.
- R9: The sample output holds its last value between valid strobes, including across a timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Conversion request, acted on only when idle |
| adc_sdo_i | input | 1 | Converter data line, high while released |
| adc_cnv_o | output | 1 | Convert output to the converter |
| adc_sclk_o | output | 1 | Serial clock to the converter, idles low |
| smp_data_o | output | DW | Last captured sample |
| smp_valid_o | output | 1 | One-cycle strobe for a new sample |
| tmo_err_o | output | 1 | One-cycle strobe when no end of conversion was seen in time |

## Verification
The convert output is due one cycle after an accepted start and falls CNV_HI cycles later. The error strobe is due T_MAX+TMO cycles after the convert rise, and the valid strobe is due in the very cycle the serial clock shows its 17th fall. The bench stamps every edge with a cycle counter that advances on the rising clock edge, and it samples all outputs on the falling edge. Each of these latencies is therefore checked as an exact difference of cycle stamps, and the phase lengths are checked as exact counts of falling-edge samples. Start pulses injected during a conversion are placed in a window that must still be busy, so any extra convert rise is counted as a failure.

// File: rtl/adc_rdout_pkg.sv
package adc_rdout_pkg;
   typedef enum logic [1:0] {
      ST_IDLE,
      ST_CNV,
      ST_WAIT,
      ST_READ
   } rd_state_e;
endpackage

// File: rtl/adc_rdout_sync.sv
module adc_rdout_sync #(
   parameter int   N       = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   logic [N-1:0] stg_q;

   initial begin : p_chk
      assert (N >= 2) else $fatal(1, "sync needs at least two stages");
   end

   for (genvar g = 0; g < N; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[g] <= RST_VAL;
            else        stg_q[g] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[g] <= RST_VAL;
            else        stg_q[g] <= stg_q[g-1];
         end
      end
   end

   assign q_o = stg_q[N-1];
endmodule

// File: rtl/adc_rdout_sclk.sv
module adc_rdout_sclk #(
   parameter int HALF = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   output logic sclk_o,
   output logic fall_o
);
   localparam int PW = (HALF > 1) ? $clog2(HALF) : 1;
   localparam logic [PW-1:0] PH_END = PW'(HALF - 1);

   logic [PW-1:0] ph_q;
   logic          sclk_q;

   initial begin : p_chk
      assert (HALF >= 3) else $fatal(1, "HALF must be at least 3 for sync margin");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q   <= '0;
         sclk_q <= 1'b0;
      end else if (!en_i) begin
         ph_q   <= '0;
         sclk_q <= 1'b0;
      end else if (ph_q == PH_END) begin
         ph_q   <= '0;
         sclk_q <= ~sclk_q;
      end else begin
         ph_q <= ph_q + 1'b1;
      end
   end

   assign fall_o = en_i && sclk_q && (ph_q == PH_END);
   assign sclk_o = sclk_q;

   // R5: clock parks low as soon as it is disabled
   a_r5_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> !sclk_q);
endmodule

// File: rtl/adc_rdout_shreg.sv
module adc_rdout_shreg #(
   parameter int SW = 15
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          shift_i,
   input  logic          bit_i,
   output logic [SW-1:0] word_o
);
   logic [SW-1:0] sh_q;

   initial begin : p_chk
      assert (SW >= 1) else $fatal(1, "shift register width must be positive");
   end

   for (genvar g = 0; g < SW; g++) begin : g_bit
      if (g == 0) begin : g_lsb
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       sh_q[g] <= 1'b0;
            else if (shift_i) sh_q[g] <= bit_i;
         end
      end else begin : g_up
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       sh_q[g] <= 1'b0;
            else if (shift_i) sh_q[g] <= sh_q[g-1];
         end
      end
   end

   assign word_o = sh_q;
endmodule

// File: rtl/adc_rdout_ctrl.sv
module adc_rdout_ctrl
   import adc_rdout_pkg::*;
#(
   parameter int DW     = 16,
   parameter int CNV_HI = 4,
   parameter int T_MIN  = 20,
   parameter int T_MAX  = 40,
   parameter int TMO    = 30,
   parameter int HALF   = 4,
   parameter int SYNC_N = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic          adc_sdo_i,
   output logic          adc_cnv_o,
   output logic          adc_sclk_o,
   output logic [DW-1:0] smp_data_o,
   output logic          smp_valid_o,
   output logic          tmo_err_o
);
   localparam int TLIM = T_MAX + TMO;
   localparam int CW   = $clog2(TLIM + 1);
   localparam int FW   = $clog2(DW + 2);
   localparam logic [CW-1:0] CNT_HI_END  = CW'(CNV_HI - 1);
   localparam logic [CW-1:0] CNT_TMO_END = CW'(TLIM - 1);
   localparam logic [FW-1:0] F_LAST      = FW'(DW);

   initial begin : p_chk
      assert (DW >= 2)                    else $fatal(1, "DW too small");
      assert (CNV_HI >= 1)                else $fatal(1, "CNV_HI must be positive");
      assert (CNV_HI < T_MIN)             else $fatal(1, "convert pulse must end before T_MIN");
      assert (T_MIN <= T_MAX)             else $fatal(1, "T_MIN above T_MAX");
      assert (TMO >= 1)                   else $fatal(1, "TMO must be positive");
   end

   rd_state_e      state_q;
   logic [CW-1:0]  cnt_q;
   logic [FW-1:0]  fcnt_q;
   logic           cnv_q;
   logic           valid_q;
   logic           err_q;
   logic [DW-1:0]  data_q;
   logic           sdo_s;
   logic           sclk_en;
   logic           sclk_fall;
   logic           shift_en;
   logic [DW-2:0]  sh_word;

   adc_rdout_sync #(.N(SYNC_N), .RST_VAL(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (adc_sdo_i),
      .q_o   (sdo_s)
   );

   assign sclk_en = (state_q == ST_READ);

   adc_rdout_sclk #(.HALF(HALF)) u_sclk (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_i   (sclk_en),
      .sclk_o (adc_sclk_o),
      .fall_o (sclk_fall)
   );

   // first fall only launches the MSB; the last fall completes the word below
   assign shift_en = sclk_fall && (fcnt_q != '0) && (fcnt_q != F_LAST);

   adc_rdout_shreg #(.SW(DW - 1)) u_shreg (
      .clk     (clk),
      .rst_n   (rst_n),
      .shift_i (shift_en),
      .bit_i   (sdo_s),
      .word_o  (sh_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         fcnt_q  <= '0;
         cnv_q   <= 1'b0;
         valid_q <= 1'b0;
         err_q   <= 1'b0;
         data_q  <= '0;
      end else begin
         valid_q <= 1'b0;
         err_q   <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  state_q <= ST_CNV;
                  cnv_q   <= 1'b1;
                  cnt_q   <= '0;
               end
            end
            ST_CNV: begin
               cnt_q <= cnt_q + 1'b1;
               if (cnt_q == CNT_HI_END) begin
                  cnv_q   <= 1'b0;
                  state_q <= ST_WAIT;
               end
            end
            ST_WAIT: begin
               cnt_q <= cnt_q + 1'b1;
               if (!sdo_s) begin
                  state_q <= ST_READ;
                  fcnt_q  <= '0;
               end else if (cnt_q == CNT_TMO_END) begin
                  err_q   <= 1'b1;
                  state_q <= ST_IDLE;
               end
            end
            ST_READ: begin
               if (sclk_fall) begin
                  fcnt_q <= fcnt_q + 1'b1;
                  if (fcnt_q == F_LAST) begin
                     data_q  <= {sh_word, sdo_s};
                     valid_q <= 1'b1;
                     state_q <= ST_IDLE;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign adc_cnv_o   = cnv_q;
   assign smp_data_o  = data_q;
   assign smp_valid_o = valid_q;
   assign tmo_err_o   = err_q;

   // R2: convert pulse length
   a_r2_cnv_width: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cnv_q) |-> (cnt_q == CW'(CNV_HI)));
   // R3: convert rises only out of idle
   a_r3_cnv_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cnv_q) |-> ($past(state_q) == ST_IDLE));
   // R4: readout entered only after the synchronized line was low
   a_r4_read_after_low: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_READ && $past(state_q) == ST_WAIT) |-> !$past(sdo_s));
   // R5: convert stays low during readout
   a_r5_cnv_low_read: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_READ) |-> !cnv_q);
   // R7: valid is a single-cycle strobe
   a_r7_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      valid_q |=> !valid_q);
   // R8: timeout never coincides with a sample
   a_r8_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(valid_q && err_q));
endmodule

// File: tb/adc_rdout_ctrl_bench.sv
`timescale 1ns/1ps
module adc_rdout_ctrl_bench;
   localparam int DW = 16, CNV_HI = 4, T_MIN = 20, T_MAX = 40, TMO = 30, HALF = 4;
   localparam int TLIM = T_MAX + TMO;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic sdo_m = 1'b1;
   logic cnv, sclk, valid, err;
   logic [DW-1:0] data;

   always #2 clk = ~clk;

   adc_rdout_ctrl #(.DW(DW), .CNV_HI(CNV_HI), .T_MIN(T_MIN), .T_MAX(T_MAX),
                    .TMO(TMO), .HALF(HALF), .SYNC_N(2)) u_adc_rdout_ctrl (
      .clk (clk), .rst_n (rst_n), .start_i (start), .adc_sdo_i (sdo_m),
      .adc_cnv_o (cnv), .adc_sclk_o (sclk), .smp_data_o (data),
      .smp_valid_o (valid), .tmo_err_o (err)
   );

   int checks = 0, fails = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // converter model, reacting at rising edges
   logic [DW-1:0] m_word = '0;
   int  m_delay = 0;
   bit  m_resp = 1;
   int  m_left = 0;
   int  m_falls = 0;
   bit  m_act = 0, m_busy = 0;
   logic cnv_pm = 0, sclk_pm = 0;

   always @(posedge clk) begin
      cnv_pm  <= cnv;
      sclk_pm <= sclk;
      if (cnv && !cnv_pm) begin
         m_act <= 1; m_busy <= 0; m_left <= m_delay; m_falls <= 0; sdo_m <= 1'b1;
      end else if (m_act && !m_busy && m_resp) begin
         if (m_left == 0) begin sdo_m <= 1'b0; m_busy <= 1; end
         else m_left <= m_left - 1;
      end else if (m_busy && sclk_pm && !sclk) begin
         m_falls <= m_falls + 1;
         if (m_falls < DW) sdo_m <= m_word[DW-1-m_falls];
         else begin sdo_m <= 1'b1; m_act <= 0; m_busy <= 0; end
      end
   end

   // monitor, sampling at falling edges
   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   logic cnv_n = 0, sclk_n = 0;
   int rise_cyc = 0, cnv_len = 0, ph_len = 0, mon_falls = 0, cnv_rises = 0;
   int got_valid = 0, got_err = 0;
   bit seen_low = 0;
   logic [DW-1:0] exp_word = '0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (cnv && !cnv_n) begin
            rise_cyc = cyc; cnv_rises++; mon_falls = 0; cnv_len = 1; seen_low = 0;
         end else if (cnv) cnv_len++;
         if (!cnv && cnv_n) chk(cnv_len == CNV_HI, "R2 convert width", cnv_len, CNV_HI);
         if (!sdo_m) seen_low = 1;
         if (sclk && !sclk_n) begin
            chk(seen_low, "R4 clock before busy low", 0, 1);
            if (mon_falls > 0) chk(ph_len == HALF, "R5 low phase", ph_len, HALF);
            ph_len = 1;
         end else if (!sclk && sclk_n) begin
            mon_falls++;
            chk(ph_len == HALF, "R5 high phase", ph_len, HALF);
            ph_len = 1;
         end else ph_len++;
         if (valid) begin
            got_valid++;
            chk(!sclk && sclk_n && mon_falls == 17, "R7 valid on 17th fall", mon_falls, 17);
            chk(data == exp_word, "R6 sample", data, exp_word);
         end
         if (err) begin
            got_err++;
            chk(cyc - rise_cyc == TLIM, "R8 timeout latency", cyc - rise_cyc, TLIM);
         end
      end
      cnv_n  = cnv;
      sclk_n = sclk;
   end

   task automatic xfer(input logic [DW-1:0] w, input int dly, input bit resp, input bit spam);
      int n;
      logic [DW-1:0] prev;
      prev = data;
      m_word = w; m_delay = dly; m_resp = resp; exp_word = w;
      got_valid = 0; got_err = 0; cnv_rises = 0;
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      chk(cnv == 1'b1, "R2 convert next cycle", cnv, 1);
      n = 0;
      while (got_valid == 0 && got_err == 0 && n < 3000) begin
         @(negedge clk);
         n++;
         start = (spam && n >= 2 && n <= T_MIN && (n % 5) == 2);
      end
      start = 1'b0;
      repeat (3) @(negedge clk);
      chk(cnv_rises == 1, "R3 single convert rise", cnv_rises, 1);
      if (resp) begin
         chk(got_valid == 1 && got_err == 0, "R6 one sample", got_valid, 1);
         chk(data == w, "R9 sample held", data, w);
      end else begin
         chk(got_err == 1 && got_valid == 0, "R8 error only", got_err, 1);
         chk(mon_falls == 0, "R8 no clock", mon_falls, 0);
         chk(data == prev, "R9 held across timeout", data, prev);
      end
      chk(!sclk && !cnv, "R5 idle low", sclk, 0);
   endtask

   initial begin
      void'($urandom(32'h5eed1234));
      repeat (4) @(negedge clk);
      chk(!cnv && !sclk && !valid && !err && data == '0, "R1 in reset", data, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!cnv && !sclk && !valid && !err && data == '0, "R1 after reset", data, 0);
      xfer(16'h8001, T_MIN, 1, 0);
      xfer(16'hFFFF, T_MAX, 1, 1);
      xfer(16'h0000, T_MIN + 5, 1, 1);
      xfer(16'h5AA5, T_MAX, 1, 0);
      for (int i = 0; i < 24; i++)
         xfer(DW'($urandom), T_MIN + int'($urandom % (T_MAX - T_MIN + 1)), 1, bit'($urandom % 2));
      xfer(16'h1234, 0, 0, 1);
      xfer(16'hC3C3, T_MIN, 1, 0);
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++; fails++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("  [TB] %0d tests run, %0d failed", checks, fails);
         $finish;
      end
   end
endmodule